// File: doc/BRIEF.md
# Clock-Receiving Serial Frame Receiver with Mode-Selected Interrupts

This block receives the data side of a two-wire, I2C-style serial link on which another device drives the serial clock. It oversamples that external clock and the data line with the system clock and reads one bit on each rising serial clock edge. It collects frames of nine bits: eight data bits, most significant first, and then an acknowledge bit. Each completed frame is written into a receive buffer. The buffer is parameterised to 16 bits. The data byte sits in the lowest bits, the acknowledge bit sits directly above it, and every remaining upper bit reads zero.

Two configuration inputs decide when the buffer is written and which strobes are raised. The interrupt-select input chooses between an acknowledge/not-acknowledge interrupt pair and a receive/transmit interrupt pair. The clock-delay input, when the receive/transmit pair is selected, causes the byte to be written at the end of the eighth bit, ahead of the ninth. Every strobe is a pulse one system clock wide. The DMA request follows either the acknowledge interrupt or the receive interrupt. A surrounding controller reads the buffer after a strobe.

Top module: `serial_rx_frame`

## Requirements
- R1: The data line is sampled on each rising edge of the serial clock, and the bit position advances on each falling edge. Nine bits form a frame. The first bit received is data bit 7, the eighth is data bit 0, and the ninth is the acknowledge bit (0 = ACK, 1 = NACK).
- R2: With interrupt-select = 0, or with clock-delay = 0, the buffer is written exactly once per frame, after the falling edge that ends the ninth bit. Bits 7..0 take the byte and bit 8 takes the acknowledge bit. After the eighth bit the buffer still holds its previous value.
- R3: Buffer bits 15..9 always read zero.
- R4: With interrupt-select = 0, one pulse is raised on `ack_irq` after the ninth bit when the acknowledge bit is 0, and one pulse on `nack_irq` when it is 1. Neither `rx_irq` nor `tx_irq` pulses in this mode.
- R5: With interrupt-select = 0, `dma_req` pulses together with `ack_irq` and never with `nack_irq`.
- R6: With interrupt-select = 1, `tx_irq` pulses once per frame after the ninth bit, and neither `ack_irq` nor `nack_irq` pulses.
- R7: With interrupt-select = 1, `rx_irq` and `dma_req` pulse together once per frame. With clock-delay = 1 this happens after the eighth bit. With clock-delay = 0 it happens after the ninth bit, in the same system clock cycle as `tx_irq`.
- R8: With interrupt-select = 1 and clock-delay = 1, the buffer is written twice per frame. After the eighth bit, bits 7..0 take the byte and bit 8 keeps its old value. After the ninth bit, bit 8 takes the acknowledge bit.
- R9: Every strobe output is high for exactly one system clock cycle at a time.
- R10: Reset clears the buffer, the bit position and all strobes. A frame that starts after reset is received from its first bit, whatever partial frame was in progress when reset was applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| scl_in | input | 1 | Serial clock driven by the remote device |
| sda_in | input | 1 | Serial data line |
| irq_sel | input | 1 | 0: ACK/NACK interrupts, 1: receive/transmit interrupts |
| clk_delay | input | 1 | 1: early byte write after the eighth bit (with irq_sel = 1) |
| rx_buf | output | 16 | Receive buffer |
| ack_irq | output | 1 | Acknowledge interrupt pulse |
| nack_irq | output | 1 | Not-acknowledge interrupt pulse |
| rx_irq | output | 1 | Receive interrupt pulse |
| tx_irq | output | 1 | Transmit interrupt pulse |
| dma_req | output | 1 | DMA request pulse |

## Verification
With interrupt-select = 1 and clock-delay = 0, the receive strobe and the transmit strobe fire in the same system clock cycle, and the buffer write also lands in that cycle. The bench drives frames in this mode, both directed and drawn at random among the other mode combinations. A monitor counts the cycles in which both strobes are high. The bench expects exactly one such cycle per frame in this mode and none with clock-delay = 1, where the receive strobe has already fired at the eighth bit.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;

   typedef struct packed {
      logic ack;
      logic nack;
      logic rx;
      logic tx;
      logic dma;
   } rx_strobe_t;

   localparam rx_strobe_t STROBE_IDLE = '{ack: 1'b0, nack: 1'b0, rx: 1'b0, tx: 1'b0, dma: 1'b0};

endpackage

// File: rtl/serial_rx_sync.sv
module serial_rx_sync #(
   parameter int STAGES = 2,
   parameter int WIDTH  = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] async_in,
   output logic [WIDTH-1:0] sync_out
);

   if (STAGES < 2) begin : g_bad_stages
      $error("serial_rx_sync: STAGES must be at least 2");
   end

   for (genvar w = 0; w < WIDTH; w++) begin : g_line
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain <= '0;
         else        chain <= {chain[STAGES-2:0], async_in[w]};
      end
      assign sync_out[w] = chain[STAGES-1];
   end

endmodule

// File: rtl/serial_rx_framer.sv
module serial_rx_framer #(
   parameter int DATA_BITS = 8,
   localparam int FRAME_W  = DATA_BITS + 1,
   localparam int IDX_W    = $clog2(FRAME_W)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               scl_s,
   input  logic               sda_s,
   output logic               byte_done,
   output logic               frame_done,
   output logic [FRAME_W-1:0] frame_bits
);

   localparam logic [IDX_W-1:0] LAST_DATA = IDX_W'(DATA_BITS - 1);
   localparam logic [IDX_W-1:0] ACK_POS   = IDX_W'(DATA_BITS);

   logic             scl_q;
   logic             scl_rise;
   logic             scl_fall;
   logic [IDX_W-1:0] bit_idx;

   assign scl_rise = scl_s & ~scl_q;
   assign scl_fall = ~scl_s & scl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) scl_q <= 1'b0;
      else        scl_q <= scl_s;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        frame_bits <= '0;
      else if (scl_rise) frame_bits <= {frame_bits[FRAME_W-2:0], sda_s};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bit_idx    <= '0;
         byte_done  <= 1'b0;
         frame_done <= 1'b0;
      end else begin
         byte_done  <= scl_fall && (bit_idx == LAST_DATA);
         frame_done <= scl_fall && (bit_idx == ACK_POS);
         if (scl_fall) begin
            if (bit_idx == ACK_POS) bit_idx <= '0;
            else                    bit_idx <= bit_idx + 1'b1;
         end
      end
   end

   AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      bit_idx <= ACK_POS);                                         // R1
   AST_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(byte_done && frame_done));                                 // R1
   AST_FRAME_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      frame_done |-> (bit_idx == '0));                             // R1

endmodule

// File: rtl/serial_rx_ctrl.sv
module serial_rx_ctrl
   import serial_rx_pkg::*;
#(
   parameter int DATA_BITS = 8,
   localparam int FRAME_W  = DATA_BITS + 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 irq_sel,
   input  logic                 clk_delay,
   input  logic                 byte_done,
   input  logic                 frame_done,
   input  logic [FRAME_W-1:0]   frame_bits,
   output logic                 load_lo,
   output logic                 load_hi,
   output logic [DATA_BITS-1:0] lo_data,
   output logic                 hi_bit,
   output rx_strobe_t           strobe
);

   logic ack_bit;
   logic rx_event;
   logic early_load;

   assign ack_bit    = frame_bits[0];
   assign early_load = irq_sel && clk_delay;
   assign rx_event   = irq_sel && (clk_delay ? byte_done : frame_done);

   always_comb begin
      load_lo = frame_done || (byte_done && early_load);
      load_hi = frame_done;
      hi_bit  = ack_bit;
      if (byte_done) lo_data = frame_bits[DATA_BITS-1:0];
      else           lo_data = frame_bits[FRAME_W-1:1];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         strobe <= STROBE_IDLE;
      end else begin
         strobe.ack  <= frame_done && !irq_sel && !ack_bit;
         strobe.nack <= frame_done && !irq_sel && ack_bit;
         strobe.tx   <= frame_done && irq_sel;
         strobe.rx   <= rx_event;
         strobe.dma  <= rx_event || (frame_done && !irq_sel && !ack_bit);
      end
   end

   AST_ACK_NACK_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(strobe.ack && strobe.nack));                               // R4
   AST_DMA_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
      strobe.dma |-> (strobe.ack || strobe.rx));                   // R5
   AST_NACK_NO_DMA: assert property (@(posedge clk) disable iff (!rst_n)
      strobe.nack |-> !strobe.dma);                                // R5
   AST_ACK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      strobe.ack |=> !strobe.ack);                                 // R9
   AST_RX_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      strobe.rx |=> !strobe.rx);                                   // R9
   AST_TX_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      strobe.tx |=> !strobe.tx);                                   // R9

endmodule

// File: rtl/serial_rx_rbuf.sv
module serial_rx_rbuf #(
   parameter int DATA_BITS = 8,
   parameter int BUF_W     = 16,
   localparam int FRAME_W  = DATA_BITS + 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 load_lo,
   input  logic                 load_hi,
   input  logic [DATA_BITS-1:0] lo_data,
   input  logic                 hi_bit,
   output logic [BUF_W-1:0]     rbuf
);

   logic [DATA_BITS-1:0] lo_q;
   logic                 hi_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lo_q <= '0;
         hi_q <= 1'b0;
      end else begin
         if (load_lo) lo_q <= lo_data;
         if (load_hi) hi_q <= hi_bit;
      end
   end

   if (BUF_W > FRAME_W) begin : g_padded
      assign rbuf = {{(BUF_W - FRAME_W){1'b0}}, hi_q, lo_q};
   end else begin : g_exact
      assign rbuf = {hi_q, lo_q};
   end

   AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (rbuf >> FRAME_W) == '0);                                    // R3
   AST_HI_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (load_lo && !load_hi) |=> (rbuf[DATA_BITS] == $past(rbuf[DATA_BITS]))); // R8

endmodule

// File: rtl/serial_rx_frame.sv
module serial_rx_frame
   import serial_rx_pkg::*;
#(
   parameter int DATA_BITS   = 8,
   parameter int BUF_W       = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             scl_in,
   input  logic             sda_in,
   input  logic             irq_sel,
   input  logic             clk_delay,
   output logic [BUF_W-1:0] rx_buf,
   output logic             ack_irq,
   output logic             nack_irq,
   output logic             rx_irq,
   output logic             tx_irq,
   output logic             dma_req
);

   localparam int FRAME_W = DATA_BITS + 1;

   if (DATA_BITS < 2) begin : g_bad_data
      $error("serial_rx_frame: DATA_BITS must be at least 2");
   end
   if (BUF_W < FRAME_W) begin : g_bad_buf
      $error("serial_rx_frame: BUF_W must hold a whole frame");
   end

   logic [1:0]           line_s;
   logic                 byte_done;
   logic                 frame_done;
   logic [FRAME_W-1:0]   frame_bits;
   logic                 load_lo;
   logic                 load_hi;
   logic [DATA_BITS-1:0] lo_data;
   logic                 hi_bit;
   rx_strobe_t           strobe;

   serial_rx_sync #(.STAGES(SYNC_STAGES), .WIDTH(2)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_in ({scl_in, sda_in}),
      .sync_out (line_s)
   );

   serial_rx_framer #(.DATA_BITS(DATA_BITS)) u_framer (
      .clk        (clk),
      .rst_n      (rst_n),
      .scl_s      (line_s[1]),
      .sda_s      (line_s[0]),
      .byte_done  (byte_done),
      .frame_done (frame_done),
      .frame_bits (frame_bits)
   );

   serial_rx_ctrl #(.DATA_BITS(DATA_BITS)) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .irq_sel    (irq_sel),
      .clk_delay  (clk_delay),
      .byte_done  (byte_done),
      .frame_done (frame_done),
      .frame_bits (frame_bits),
      .load_lo    (load_lo),
      .load_hi    (load_hi),
      .lo_data    (lo_data),
      .hi_bit     (hi_bit),
      .strobe     (strobe)
   );

   serial_rx_rbuf #(.DATA_BITS(DATA_BITS), .BUF_W(BUF_W)) u_rbuf (
      .clk     (clk),
      .rst_n   (rst_n),
      .load_lo (load_lo),
      .load_hi (load_hi),
      .lo_data (lo_data),
      .hi_bit  (hi_bit),
      .rbuf    (rx_buf)
   );

   assign ack_irq  = strobe.ack;
   assign nack_irq = strobe.nack;
   assign rx_irq   = strobe.rx;
   assign tx_irq   = strobe.tx;
   assign dma_req  = strobe.dma;

   AST_STROBE_WITH_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_irq || ack_irq || nack_irq) |-> $past(load_hi));         // R2
   AST_DMA_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      dma_req |=> !dma_req);                                       // R9

endmodule

// File: tb/serial_rx_frame_tb.sv
module serial_rx_frame_tb_top;

   localparam int HALF = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        scl_in = 1'b0;
   logic        sda_in = 1'b0;
   logic        irq_sel = 1'b0;
   logic        clk_delay = 1'b0;
   logic [15:0] rx_buf;
   logic        ack_irq, nack_irq, rx_irq, tx_irq, dma_req;

   int checks = 0;
   int errors = 0;

   int n_ack = 0, n_nack = 0, n_rx = 0, n_tx = 0, n_dma = 0, n_both = 0, n_wide = 0;
   logic p_ack = 0, p_nack = 0, p_rx = 0, p_tx = 0, p_dma = 0;

   logic [15:0] model_buf;

   always #5 clk = ~clk;

   serial_rx_frame dut_i (
      .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
      .irq_sel(irq_sel), .clk_delay(clk_delay), .rx_buf(rx_buf),
      .ack_irq(ack_irq), .nack_irq(nack_irq), .rx_irq(rx_irq),
      .tx_irq(tx_irq), .dma_req(dma_req)
   );

   always @(negedge clk) begin
      if (rst_n) begin
         n_ack  <= n_ack  + int'(ack_irq);
         n_nack <= n_nack + int'(nack_irq);
         n_rx   <= n_rx   + int'(rx_irq);
         n_tx   <= n_tx   + int'(tx_irq);
         n_dma  <= n_dma  + int'(dma_req);
         n_both <= n_both + int'(rx_irq && tx_irq);
         n_wide <= n_wide + int'((ack_irq && p_ack) || (nack_irq && p_nack) ||
                                 (rx_irq && p_rx) || (tx_irq && p_tx) || (dma_req && p_dma));
      end
      p_ack <= ack_irq; p_nack <= nack_irq; p_rx <= rx_irq; p_tx <= tx_irq; p_dma <= dma_req;
   end

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   function automatic logic [15:0] exp_full(input logic [7:0] b, input logic a);
      return {7'b0, a, b};
   endfunction

   function automatic logic [15:0] exp_mid(input logic [15:0] prev, input logic [7:0] b,
                                          input logic is, input logic dl);
      if (is && dl) return {7'b0, prev[8], b};
      return prev;
   endfunction

   task automatic send_frame(input logic [7:0] b, input logic a, input logic is, input logic dl);
      int s_ack, s_nack, s_rx, s_tx, s_dma, s_both, s_wide;
      logic [8:0] bits;
      bits = {b, a};
      irq_sel = is; clk_delay = dl;
      s_ack = n_ack; s_nack = n_nack; s_rx = n_rx; s_tx = n_tx;
      s_dma = n_dma; s_both = n_both; s_wide = n_wide;
      for (int i = 0; i < 9; i++) begin
         sda_in = bits[8-i];
         tick(HALF);
         scl_in = 1'b1;
         tick(HALF);
         scl_in = 1'b0;
         tick(HALF);
         if (i == 7) begin
            check(is && dl ? "R8 early byte write" : "R2 no write after bit 8",
                  int'(rx_buf), int'(exp_mid(model_buf, b, is, dl)));
            check("R7 rx strobe after bit 8", n_rx - s_rx, (is && dl) ? 1 : 0);
         end
      end
      model_buf = exp_full(b, a);
      check(is && dl ? "R8 second write" : "R2 R1 frame write", int'(rx_buf), int'(model_buf));
      check("R3 upper bits zero", int'(rx_buf[15:9]), 0);
      check("R4 ack count",  n_ack  - s_ack,  (!is && !a) ? 1 : 0);
      check("R4 nack count", n_nack - s_nack, (!is && a) ? 1 : 0);
      check("R5 R7 dma count", n_dma - s_dma, is ? 1 : (!a ? 1 : 0));
      check("R6 tx count",   n_tx - s_tx, is ? 1 : 0);
      check("R7 rx count",   n_rx - s_rx, is ? 1 : 0);
      check("R7 rx tx same cycle", n_both - s_both, (is && !dl) ? 1 : 0);
      check("R9 strobe width", n_wide - s_wide, 0);
   endtask

   initial begin
      logic [31:0] seed_sink;
      seed_sink = $urandom(32'd20240611);
      model_buf = '0;
      tick(4);
      check("R10 reset buffer", int'(rx_buf), 0);
      check("R10 reset strobes", int'({ack_irq, nack_irq, rx_irq, tx_irq, dma_req}), 0);
      rst_n = 1'b1;
      tick(4);

      send_frame(8'hA5, 1'b0, 1'b0, 1'b0);
      send_frame(8'h3C, 1'b1, 1'b0, 1'b0);
      send_frame(8'h81, 1'b1, 1'b0, 1'b1);
      send_frame(8'h5A, 1'b0, 1'b1, 1'b1);
      send_frame(8'hFF, 1'b1, 1'b1, 1'b0);
      send_frame(8'h00, 1'b0, 1'b1, 1'b1);
      send_frame(8'h7E, 1'b1, 1'b1, 1'b1);

      for (int k = 0; k < 4; k++) begin
         sda_in = k[0];
         tick(HALF); scl_in = 1'b1; tick(HALF); scl_in = 1'b0; tick(HALF);
      end
      rst_n = 1'b0;
      tick(3);
      check("R10 reset mid-frame buffer", int'(rx_buf), 0);
      check("R10 reset mid-frame strobes", int'({ack_irq, nack_irq, rx_irq, tx_irq, dma_req}), 0);
      rst_n = 1'b1;
      model_buf = '0;
      tick(4);
      send_frame(8'hC3, 1'b0, 1'b0, 1'b0);

      for (int r = 0; r < 24; r++) begin
         send_frame(8'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule